// File: doc/BRIEF.md
# Multi-Port Distributed Word Memory

This block is a small memory of the kind built from look-up-table storage cells. It has 64 words by default, and the word width is a parameter. Every port has its own address input, and all ports share one storage array. Writes take effect on the rising clock edge. Reads are combinational from the address.

A mode parameter sets how many ports read and which one writes:
- Single-port: one read/write port.
- Dual-port: one read/write port plus one read-only port.
- Simple dual-port: one write-only port plus one read-only port.
- Quad-port: one read/write port plus three read-only ports.

A per-port bit mask can insert an output flip-flop on any read port. This turns that port's read from asynchronous into synchronous. The default geometry, 64 words of 1 bit, can also be set up as 32 words of 2 bits through the parameters.

Top module: `lutram_multiport`

## Requirements
- R1: When `we` is 1 at a rising clock edge, `wr_data` is stored at the write address. The write address is `addr_a`, except in simple dual-port mode, where it is `wr_addr`.
- R2: A read port without an output register drives the word at its current address on its data output combinationally, with no clock edge needed.
- R3: A read port whose bit in `OUT_REG` is 1 (bit 0 = port A through bit 3 = port D) shows the word at its address one rising edge later. While `rst_n` is 0 it outputs zero.
- R4: In quad-port mode (`PORT_MODE` = 3), port A reads and writes, and ports B, C and D read through their own independent addresses.
- R5: In simple dual-port mode (`PORT_MODE` = 2), the write uses `wr_addr` and ignores `addr_a`, and port B is the read port.
- R6: When an unregistered read-only port addresses the word being written, its output shows the new data right after that write edge. Before the edge it shows the old data.
- R7: Ports that the mode does not use for reading drive zero: port A in simple dual-port mode; ports C and D in single-port, dual-port and simple dual-port modes; port B in single-port mode.
- R8: When `we` is 0 at an edge, no word changes, whatever the addresses and data.
- R9: `PORT_MODE` encodes single-port = 0, dual-port = 1, simple dual-port = 2, quad-port = 3. Elaboration rejects a width below 1 and a depth that is not a power of two of at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and output registers act on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the read output registers |
| we | input | 1 | Write enable, active high |
| wr_addr | input | ADDR_W | Write address in simple dual-port mode |
| wr_data | input | DATA_W | Data to write |
| addr_a | input | ADDR_W | Port A address (also the write address outside simple dual-port mode) |
| addr_b | input | ADDR_W | Port B read address |
| addr_c | input | ADDR_W | Port C read address |
| addr_d | input | ADDR_W | Port D read address |
| dout_a | output | DATA_W | Port A read data |
| dout_b | output | DATA_W | Port B read data |
| dout_c | output | DATA_W | Port C read data |
| dout_d | output | DATA_W | Port D read data |

## Verification
The hardest case to reach is a read-only port aimed at the very word the write port is updating. The port must show the old word before the edge and the new word just after it, while the other ports keep reading unrelated words. The bench steers port B onto the active write address, samples before and after that edge, and checks that port A's own read changes at the same moment.

A second instance runs in simple dual-port mode. In it, `addr_a` deliberately walks one word ahead of `wr_addr`, so any write that used the wrong address shows up in a full readback.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

   localparam int unsigned NUM_PORTS = 4;

   typedef enum logic [1:0] {
      PM_SINGLE      = 2'd0,
      PM_DUAL        = 2'd1,
      PM_SIMPLE_DUAL = 2'd2,
      PM_QUAD        = 2'd3
   } port_mode_e;

   // whether port p (0 = A .. 3 = D) drives read data in mode m
   function automatic bit port_reads(port_mode_e m, int p);
      case (m)
         PM_SINGLE:      return p == 0;
         PM_DUAL:        return p <= 1;
         PM_SIMPLE_DUAL: return p == 1;
         default:        return 1'b1;
      endcase
   endfunction

   function automatic bit separate_writer(port_mode_e m);
      return m == PM_SIMPLE_DUAL;
   endfunction

endpackage

// File: rtl/lutram_store.sv
module lutram_store #(
   parameter int unsigned DATA_W = 1,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned NPORT  = 4,
   localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [ADDR_W-1:0]            waddr,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [NPORT-1:0][ADDR_W-1:0] raddr,
   output logic [NPORT-1:0][DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_rd
      assign rdata[p] = cells[raddr[p]];
   end

   // R1
   wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> cells[$past(waddr)] == $past(wdata));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> cells[$past(waddr)] == $past(cells[waddr]));

endmodule

// File: rtl/lutram_rdport.sv
module lutram_rdport #(
   parameter int unsigned DATA_W     = 1,
   parameter bit          ACTIVE     = 1'b1,
   parameter bit          REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rd_in,
   output logic [DATA_W-1:0] rd_out
);

   if (!ACTIVE) begin : g_off
      logic unused_sink;
      assign unused_sink = ^{clk, rst_n, rd_in};
      assign rd_out = '0;
   end else if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_out <= '0;
         else        rd_out <= rd_in;
      end

      // R3
      reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n && $past(rst_n) |-> rd_out == $past(rd_in));

      // R3
      reg_clear_chk: assert property (@(posedge clk)
         !rst_n |-> rd_out == '0);
   end else begin : g_comb
      logic unused_sink;
      assign unused_sink = ^{clk, rst_n};
      assign rd_out = rd_in;
   end

endmodule

// File: rtl/lutram_multiport.sv
module lutram_multiport #(
   parameter int unsigned            DATA_W    = 1,
   parameter int unsigned            DEPTH     = 64,
   parameter lutram_pkg::port_mode_e PORT_MODE = lutram_pkg::PM_QUAD,
   parameter logic [3:0]             OUT_REG   = 4'b0000,
   localparam int unsigned           ADDR_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [ADDR_W-1:0] addr_c,
   input  logic [ADDR_W-1:0] addr_d,
   output logic [DATA_W-1:0] dout_a,
   output logic [DATA_W-1:0] dout_b,
   output logic [DATA_W-1:0] dout_c,
   output logic [DATA_W-1:0] dout_d
);
   import lutram_pkg::*;

   localparam int unsigned NP = NUM_PORTS;

   // R9 elaboration-time parameter checks
   if (DATA_W < 1) begin : g_bad_width
      $error("lutram_multiport: DATA_W must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lutram_multiport: DEPTH must be a power of two, 2 or more");
   end

   logic [ADDR_W-1:0]            waddr_sel;
   logic [NP-1:0][ADDR_W-1:0]    raddr_v;
   logic [NP-1:0][DATA_W-1:0]    rdata_v;
   logic [NP-1:0][DATA_W-1:0]    dout_v;

   if (separate_writer(PORT_MODE)) begin : g_wsep
      assign waddr_sel = wr_addr;
   end else begin : g_wa
      logic unused_sink;
      assign unused_sink = ^wr_addr;
      assign waddr_sel = addr_a;
   end

   assign raddr_v = {addr_d, addr_c, addr_b, addr_a};

   lutram_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .NPORT  (NP)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (waddr_sel),
      .wdata (wr_data),
      .raddr (raddr_v),
      .rdata (rdata_v)
   );

   for (genvar p = 0; p < NP; p++) begin : g_port
      lutram_rdport #(
         .DATA_W     (DATA_W),
         .ACTIVE     (port_reads(PORT_MODE, p)),
         .REGISTERED (OUT_REG[p])
      ) u_rd (
         .clk    (clk),
         .rst_n  (rst_n),
         .rd_in  (rdata_v[p]),
         .rd_out (dout_v[p])
      );
   end

   assign dout_a = dout_v[0];
   assign dout_b = dout_v[1];
   assign dout_c = dout_v[2];
   assign dout_d = dout_v[3];

   if (port_reads(PORT_MODE, 1) && !OUT_REG[1]) begin : g_fwd
      // R6
      fwd_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(we) && addr_b == $past(waddr_sel) |-> dout_b == $past(wr_data));
   end

   if (!port_reads(PORT_MODE, 3)) begin : g_idle_d
      // R7
      idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dout_d == '0 && $stable(dout_d));
   end

endmodule

// File: tb/tb_lutram_multiport.sv
module tb_lutram_multiport;
   import lutram_pkg::*;

   localparam int unsigned DW = 4;
   localparam int unsigned DP = 64;
   localparam int unsigned AW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int unsigned n_chk = 0;
   int unsigned n_err = 0;
   bit finished = 1'b0;

   // quad-port instance, port C registered
   logic          we = 1'b0;
   logic [AW-1:0] wr_addr = '0, addr_a = '0, addr_b = '0, addr_c = '0, addr_d = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] dout_a, dout_b, dout_c, dout_d;

   lutram_multiport #(.DATA_W(DW), .DEPTH(DP), .PORT_MODE(PM_QUAD), .OUT_REG(4'b0100)) dut (
      .clk(clk), .rst_n(rst_n), .we(we), .wr_addr(wr_addr), .wr_data(wr_data),
      .addr_a(addr_a), .addr_b(addr_b), .addr_c(addr_c), .addr_d(addr_d),
      .dout_a(dout_a), .dout_b(dout_b), .dout_c(dout_c), .dout_d(dout_d));

   // simple dual-port instance, no output registers
   logic          s_we = 1'b0;
   logic [AW-1:0] s_waddr = '0, s_addr_a = '0, s_addr_b = '0, s_addr_c = '0, s_addr_d = '0;
   logic [DW-1:0] s_wdata = '0;
   logic [DW-1:0] s_dout_a, s_dout_b, s_dout_c, s_dout_d;

   lutram_multiport #(.DATA_W(DW), .DEPTH(DP), .PORT_MODE(PM_SIMPLE_DUAL), .OUT_REG(4'b0000)) dut_sdp (
      .clk(clk), .rst_n(rst_n), .we(s_we), .wr_addr(s_waddr), .wr_data(s_wdata),
      .addr_a(s_addr_a), .addr_b(s_addr_b), .addr_c(s_addr_c), .addr_d(s_addr_d),
      .dout_a(s_dout_a), .dout_b(s_dout_b), .dout_c(s_dout_c), .dout_d(s_dout_d));

   function automatic logic [DW-1:0] pat_q(int i);
      return DW'((i * 5 + 3) % 16);
   endfunction

   function automatic logic [DW-1:0] pat_s(int i);
      return DW'((i * 11 + 6) % 16);
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
   end

   initial begin
      // R3 registered port is zero during reset
      repeat (2) @(negedge clk);
      chk("R3 reset", dout_c, '0);
      rst_n = 1'b1;

      // R1 fill quad instance through port A
      for (int i = 0; i < DP; i++) begin
         @(negedge clk);
         we = 1'b1; addr_a = AW'(i); wr_data = pat_q(i);
      end
      @(negedge clk);
      we = 1'b0;

      // R2 R4 independent combinational reads; R3 registered port C
      for (int i = 0; i < DP; i++) begin
         @(negedge clk);
         addr_a = AW'(i); addr_b = AW'((i + 17) % DP);
         addr_c = AW'((i + 33) % DP); addr_d = AW'((i + 50) % DP);
         #1;
         chk("R2 R4 port A", dout_a, pat_q(i));
         chk("R4 port B", dout_b, pat_q((i + 17) % DP));
         chk("R4 port D", dout_d, pat_q((i + 50) % DP));
         if (i > 0) chk("R3 port C before edge", dout_c, pat_q((i + 32) % DP));
         @(posedge clk); #1;
         chk("R3 port C after edge", dout_c, pat_q((i + 33) % DP));
      end

      // R8 disabled writes change nothing
      for (int i = 0; i < DP; i++) begin
         @(negedge clk);
         we = 1'b0; addr_a = AW'(i); wr_data = ~pat_q(i);
      end
      for (int i = 0; i < DP; i++) begin
         @(negedge clk);
         addr_b = AW'(i); #1;
         chk("R8 unchanged", dout_b, pat_q(i));
      end

      // R6 read-only port on the word being written
      @(negedge clk);
      we = 1'b1; addr_a = 6'd5; wr_data = 4'hE; addr_b = 6'd5; addr_d = 6'd6;
      #1;
      chk("R6 old before edge", dout_b, pat_q(5));
      @(posedge clk); #1;
      chk("R6 new after edge", dout_b, 4'hE);
      chk("R4 port A sees own write", dout_a, 4'hE);
      chk("R6 neighbour untouched", dout_d, pat_q(6));
      @(negedge clk);
      we = 1'b0;

      // R5 fill simple dual-port instance, addr_a walks one ahead
      for (int i = 0; i < DP; i++) begin
         @(negedge clk);
         s_we = 1'b1; s_waddr = AW'(i); s_addr_a = AW'((i + 1) % DP); s_wdata = pat_s(i);
      end
      @(negedge clk);
      s_we = 1'b0;
      for (int i = 0; i < DP; i++) begin
         @(negedge clk);
         s_addr_b = AW'(i); s_addr_a = AW'(i); s_addr_c = AW'(i); s_addr_d = AW'(i);
         #1;
         chk("R5 sdp readback", s_dout_b, pat_s(i));
         chk("R7 sdp port A zero", s_dout_a, '0);
         chk("R7 sdp port C zero", s_dout_c, '0);
         chk("R7 sdp port D zero", s_dout_d, '0);
      end

      // R9 mode encodings the bench relies on
      n_chk++;
      if (int'(PM_SIMPLE_DUAL) != 2 || int'(PM_QUAD) != 3) begin
         n_err++;
         $display("FAIL R9: actual=%0d/%0d expected=2/3", int'(PM_SIMPLE_DUAL), int'(PM_QUAD));
      end

      report();
   end

endmodule